// File: doc/BRIEF.md
# ADC Sample Accumulator and Output Formatter

This block sits behind the digital output of an ADC core. Each cycle in which the core strobes a 10-bit conversion word, the block refreshes a 16-bit sample register with that word in the selected presentation. In the two single-conversion modes, the 16-bit result register follows the sample register. In the two accumulation modes, the result register is only loaded once a run of 2^k conversions has been summed. On that load the sum appears raw, left-adjusted to the top bit or averaged.

A one-cycle done pulse marks every load of the result register. Configuration is taken from three plain inputs: the mode, the sample-count exponent and the scaling select. These inputs must be held steady for the length of an accumulation run.

Top module: `conv_accum_fmt`

## Requirements
- R1: A synchronous active-high reset clears the sample register, the result register and the done output to zero, and it abandons any partly summed run.
- R2: The sample register loads on the clock edge at which `conv_valid` is high. With `conv_valid` low it keeps its value, and `result_done` stays low.
- R3: In narrow single mode (`mode`=0), both registers take conversion bits [9:2] in bits [7:0], with zeros in bits [15:8]. In this mode `scale_sel` has no effect.
- R4: In every other mode the sample register holds the conversion in bits [9:0] with zeros above when `scale_sel` is 0 (none), 2 (average) or 3 (reserved). When `scale_sel` is 1 (left-adjust), it holds the conversion shifted left by 6.
- R5: In single modes (`mode` 0 or 1), each conversion also loads the result register with the same value as the sample register.
- R6: In accumulation modes (`mode` 2 = series, 3 = burst), 2^k conversions are summed, with k = `count_sel` (0..7). The result register changes only after the last conversion of the run. The sum starts from zero at each new run, and a conversion taken in a single mode ends any unfinished run.
- R7: In accumulation with `scale_sel` 0 or 3 and k at most 6, the result is the raw sum with its LSb at bit 0.
- R8: In accumulation with `scale_sel` 1 and k at most 6, the result is the sum shifted left by 6-k, so that a full-scale sum reaches bit 15.
- R9: In accumulation with `scale_sel` 2, the result is the sum shifted right by k, held in bits [9:0] with zeros above.
- R10: With k = 7 and `scale_sel` 0, 1 or 3, the result holds bits [16:1] of the 17-bit sum.
- R11: `result_done` is high for exactly the cycle after each edge that loads the result register, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Conversion word strobe |
| conv_data | input | 10 | Raw conversion word |
| mode | input | 2 | 0 narrow single, 1 full single, 2 series, 3 burst |
| count_sel | input | 3 | Run length exponent k, 2^k conversions |
| scale_sel | input | 2 | 0 none, 1 left-adjust, 2 average, 3 treated as none |
| sample_reg | output | 16 | Latest conversion, formatted |
| result_reg | output | 16 | Latest result, formatted |
| result_done | output | 1 | One-cycle pulse on each result load |

## Verification
The hardest situation to reach is the longest run (k = 7), where the 17-bit sum must be cut to its upper 16 bits. The stimulus drives 128 full-scale conversions for the raw setting and 128 unit conversions for the left-adjust setting. It checks after every conversion that the result register stays frozen until the last one arrives. A run cut short by a single-mode conversion and a run cut short by a reset are also driven. Each is followed by a fresh run whose sum must not include the abandoned samples.

// File: rtl/conv_accum_pkg.sv
package conv_accum_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE_NARROW = 2'd0,
        MODE_SINGLE_FULL   = 2'd1,
        MODE_SERIES        = 2'd2,
        MODE_BURST         = 2'd3
    } conv_mode_e;

    typedef enum logic [1:0] {
        SCL_NONE = 2'd0,
        SCL_LEFT = 2'd1,
        SCL_AVG  = 2'd2,
        SCL_RSVD = 2'd3
    } conv_scale_e;

    typedef struct packed {
        conv_mode_e  mode;
        conv_scale_e scale;
    } conv_cfg_t;

    function automatic logic mode_accumulates(conv_mode_e m);
        return (m == MODE_SERIES) || (m == MODE_BURST);
    endfunction

endpackage

// File: rtl/conv_sample_fmt.sv
module conv_sample_fmt
    import conv_accum_pkg::*;
#(
    parameter int CONV_W   = 10,
    parameter int OUT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic [CONV_W-1:0] conv,
    input  conv_cfg_t         cfg,
    output logic [OUT_W-1:0]  word
);

    always_comb begin
        word = '0;
        if (cfg.mode == MODE_SINGLE_NARROW) begin
            word[NARROW_W-1:0] = conv[CONV_W-1 -: NARROW_W];
        end else if (cfg.scale == SCL_LEFT) begin
            word[OUT_W-1 -: CONV_W] = conv;
        end else begin
            word[CONV_W-1:0] = conv;
        end
    end

endmodule

// File: rtl/conv_accum_seq.sv
module conv_accum_seq #(
    parameter int CONV_W = 10,
    parameter int SEL_W  = 3,
    parameter int ACC_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CONV_W-1:0] in_data,
    input  logic              accum_en,
    input  logic [SEL_W-1:0]  count_sel,
    output logic [ACC_W-1:0]  sum_now,
    output logic              run_last
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit    = CNT_W'((CNT_W+1)'(1) << count_sel) - CNT_W'(1);
    assign run_last = (cnt_q == limit);
    assign sum_now  = ((cnt_q == '0) ? '0 : acc_q) + ACC_W'(in_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            if (!accum_en || run_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            acc_q <= sum_now;
        end
    end

endmodule

// File: rtl/conv_result_fmt.sv
module conv_result_fmt
    import conv_accum_pkg::*;
#(
    parameter int CONV_W = 10,
    parameter int OUT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int ACC_W  = 17
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [SEL_W-1:0] count_sel,
    input  conv_scale_e      scale,
    output logic [OUT_W-1:0] word
);

    localparam int NSEL = 1 << SEL_W;

    logic [OUT_W-1:0] cand_raw  [NSEL];
    logic [OUT_W-1:0] cand_left [NSEL];
    logic [OUT_W-1:0] cand_avg  [NSEL];

    for (genvar k = 0; k < NSEL; k++) begin : g_k
        localparam int SUM_W = CONV_W + k;
        assign cand_avg[k] = OUT_W'(sum[CONV_W-1+k:k]);
        if (SUM_W <= OUT_W) begin : g_fit
            localparam int SHL = OUT_W - SUM_W;
            assign cand_raw[k]  = OUT_W'(sum);
            assign cand_left[k] = OUT_W'(sum << SHL);
        end else begin : g_over
            localparam int SHR = SUM_W - OUT_W;
            assign cand_raw[k]  = OUT_W'(sum >> SHR);
            assign cand_left[k] = OUT_W'(sum >> SHR);
        end
    end

    always_comb begin
        case (scale)
            SCL_LEFT: word = cand_left[count_sel];
            SCL_AVG:  word = cand_avg[count_sel];
            default:  word = cand_raw[count_sel];
        endcase
    end

endmodule

// File: rtl/conv_accum_fmt.sv
module conv_accum_fmt
    import conv_accum_pkg::*;
#(
    parameter int CONV_W   = 10,
    parameter int OUT_W    = 16,
    parameter int SEL_W    = 3,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic [CONV_W-1:0] conv_data,
    input  logic [1:0]        mode,
    input  logic [SEL_W-1:0]  count_sel,
    input  logic [1:0]        scale_sel,
    output logic [OUT_W-1:0]  sample_reg,
    output logic [OUT_W-1:0]  result_reg,
    output logic              result_done
);

    localparam int MAXK  = (1 << SEL_W) - 1;
    localparam int ACC_W = (CONV_W + MAXK > OUT_W) ? CONV_W + MAXK : OUT_W;

    conv_cfg_t        cfg;
    logic             accum_en;
    logic [ACC_W-1:0] sum_now;
    logic             run_last;
    logic [OUT_W-1:0] sample_word;
    logic [OUT_W-1:0] result_word;

    assign cfg.mode  = conv_mode_e'(mode);
    assign cfg.scale = conv_scale_e'(scale_sel);
    assign accum_en  = mode_accumulates(cfg.mode);

    conv_sample_fmt #(
        .CONV_W(CONV_W), .OUT_W(OUT_W), .NARROW_W(NARROW_W)
    ) u_sfmt (
        .conv(conv_data), .cfg(cfg), .word(sample_word)
    );

    conv_accum_seq #(
        .CONV_W(CONV_W), .SEL_W(SEL_W), .ACC_W(ACC_W)
    ) u_seq (
        .clk(clk), .rst(rst), .in_valid(conv_valid), .in_data(conv_data),
        .accum_en(accum_en), .count_sel(count_sel),
        .sum_now(sum_now), .run_last(run_last)
    );

    conv_result_fmt #(
        .CONV_W(CONV_W), .OUT_W(OUT_W), .SEL_W(SEL_W), .ACC_W(ACC_W)
    ) u_rfmt (
        .sum(sum_now), .count_sel(count_sel), .scale(cfg.scale),
        .word(result_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_reg  <= '0;
            result_reg  <= '0;
            result_done <= 1'b0;
        end else begin
            result_done <= 1'b0;
            if (conv_valid) begin
                sample_reg <= sample_word;
                if (!accum_en) begin
                    result_reg  <= sample_word;
                    result_done <= 1'b1;
                end else if (run_last) begin
                    result_reg  <= result_word;
                    result_done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/conv_accum_fmt_chk.sv
module conv_accum_fmt_chk #(
    parameter int CONV_W   = 10,
    parameter int OUT_W    = 16,
    parameter int SEL_W    = 3,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_valid,
    input logic [CONV_W-1:0] conv_data,
    input logic [1:0]        mode,
    input logic [SEL_W-1:0]  count_sel,
    input logic [1:0]        scale_sel,
    input logic [OUT_W-1:0]  sample_reg,
    input logic [OUT_W-1:0]  result_reg,
    input logic              result_done
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sample_reg == '0) && (result_reg == '0) && !result_done);

    a_r2_sample_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(conv_valid) && !$past(rst)) |-> ($stable(sample_reg) && !result_done));

    a_r3_narrow_top_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_valid && mode == 2'd0) && !$past(rst))
        |-> (sample_reg[OUT_W-1:NARROW_W] == '0) && (result_reg == sample_reg));

    a_r4_left_low_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_valid && mode != 2'd0 && scale_sel == 2'd1) && !$past(rst))
        |-> (sample_reg[OUT_W-CONV_W-1:0] == '0));

    a_r5_single_mirror: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_valid && !mode[1]) && !$past(rst))
        |-> result_done && (result_reg == sample_reg));

    a_r9_avg_high_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_valid && mode[1] && scale_sel == 2'd2) && !$past(rst) && result_done)
        |-> (result_reg[OUT_W-1:CONV_W] == '0));

    a_r11_change_needs_done: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(result_reg)) |-> result_done);

    a_r11_done_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !$past(conv_valid) |-> !result_done);

endmodule

bind conv_accum_fmt conv_accum_fmt_chk #(
    .CONV_W(CONV_W), .OUT_W(OUT_W), .SEL_W(SEL_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .mode(mode), .count_sel(count_sel), .scale_sel(scale_sel),
    .sample_reg(sample_reg), .result_reg(result_reg), .result_done(result_done)
);

// File: tb/conv_accum_fmt_test.sv
`timescale 1ns/1ps
module conv_accum_fmt_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_valid = 1'b0;
    logic [9:0]  conv_data = '0;
    logic [1:0]  mode = '0;
    logic [2:0]  count_sel = '0;
    logic [1:0]  scale_sel = '0;
    logic [15:0] sample_reg;
    logic [15:0] result_reg;
    logic        result_done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    conv_accum_fmt uut (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
        .mode(mode), .count_sel(count_sel), .scale_sel(scale_sel),
        .sample_reg(sample_reg), .result_reg(result_reg), .result_done(result_done)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  k;
        logic [1:0]  scale;
        logic [9:0]  val;
        logic [15:0] exp_sample;
        logic [15:0] exp_result;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd0, 2'd1, 10'h3FF, 16'h00FF, 16'h00FF},
        '{2'd1, 3'd0, 2'd0, 10'h2A5, 16'h02A5, 16'h02A5},
        '{2'd1, 3'd0, 2'd1, 10'h2A5, 16'hA940, 16'hA940},
        '{2'd1, 3'd0, 2'd2, 10'h155, 16'h0155, 16'h0155},
        '{2'd2, 3'd2, 2'd0, 10'h3FF, 16'h03FF, 16'h0FFC},
        '{2'd3, 3'd2, 2'd1, 10'h3FF, 16'hFFC0, 16'hFFC0},
        '{2'd2, 3'd3, 2'd2, 10'h123, 16'h0123, 16'h0123},
        '{2'd2, 3'd6, 2'd0, 10'h3FF, 16'h03FF, 16'hFFC0},
        '{2'd3, 3'd7, 2'd0, 10'h3FF, 16'h03FF, 16'hFFC0},
        '{2'd2, 3'd7, 2'd1, 10'h001, 16'h0040, 16'h0040},
        '{2'd2, 3'd0, 2'd1, 10'h001, 16'h0040, 16'h0040},
        '{2'd2, 3'd1, 2'd3, 10'h200, 16'h0200, 16'h0400},
        '{2'd0, 3'd0, 2'd0, 10'h003, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic [2:0] k,
                                     input logic [1:0] s);
        if (m == 2'd0) return "R3";
        if (m == 2'd1) return "R4";
        if (k == 3'd7 && s != 2'd2) return "R10";
        if (s == 2'd1) return "R8";
        if (s == 2'd2) return "R9";
        return "R7";
    endfunction

    // One strobe; returns at the following falling edge, after the load edge.
    task automatic send(input logic [9:0] v);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = v;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic idle_hold(input int n);
        logic [15:0] s0;
        s0 = sample_reg;
        repeat (n) @(negedge clk);
        check("R2", "sample held", sample_reg, s0);
        check("R11", "done idle", {15'd0, result_done}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "sample after reset", sample_reg, 16'h0000);
        check("R1", "result after reset", result_reg, 16'h0000);
        check("R1", "done after reset", {15'd0, result_done}, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            mode      = VECS[i].mode;
            count_sel = VECS[i].k;
            scale_sel = VECS[i].scale;
            n    = VECS[i].mode[1] ? (1 << VECS[i].k) : 1;
            prev = result_reg;
            for (int j = 0; j < n; j++) begin
                send(VECS[i].val);
                if (j < n - 1) begin
                    check("R6", "result frozen mid-run", result_reg, prev);
                    check("R11", "no done mid-run", {15'd0, result_done}, 16'd0);
                end
            end
            check(VECS[i].mode[1] ? "R4" : tag_of(VECS[i].mode, VECS[i].k, VECS[i].scale),
                  "sample", sample_reg, VECS[i].exp_sample);
            check(tag_of(VECS[i].mode, VECS[i].k, VECS[i].scale),
                  "result", result_reg, VECS[i].exp_result);
            check("R11", "done on load", {15'd0, result_done}, 16'd1);
            if (!VECS[i].mode[1])
                check("R5", "result mirrors sample", result_reg, sample_reg);
            idle_hold(3);
        end

        // Back-to-back strobes with distinct values, average and raw.
        mode = 2'd3; count_sel = 3'd2; scale_sel = 2'd2;
        @(negedge clk);
        conv_valid = 1'b1; conv_data = 10'd1;
        @(negedge clk); conv_data = 10'd2;
        @(negedge clk); conv_data = 10'd3;
        @(negedge clk); conv_data = 10'd10;
        @(negedge clk); conv_valid = 1'b0;
        check("R9", "average of 1,2,3,10", result_reg, 16'h0004);
        check("R11", "done back-to-back", {15'd0, result_done}, 16'd1);
        scale_sel = 2'd0;
        @(negedge clk);
        conv_valid = 1'b1; conv_data = 10'd1;
        @(negedge clk); conv_data = 10'd2;
        @(negedge clk); conv_data = 10'd3;
        @(negedge clk); conv_data = 10'd10;
        @(negedge clk); conv_valid = 1'b0;
        check("R7", "raw sum of 1,2,3,10", result_reg, 16'h0010);

        // A single-mode strobe ends an unfinished run.
        mode = 2'd2; count_sel = 3'd2; scale_sel = 2'd0;
        send(10'h100);
        send(10'h100);
        check("R6", "partial run not loaded", result_reg, 16'h0010);
        mode = 2'd1;
        send(10'h005);
        check("R5", "single load", result_reg, 16'h0005);
        mode = 2'd2; count_sel = 3'd1;
        send(10'h020);
        send(10'h030);
        check("R6", "fresh run after abort", result_reg, 16'h0050);

        // Narrow mode ignores scale.
        mode = 2'd0; scale_sel = 2'd2;
        send(10'h2A7);
        check("R3", "narrow sample", sample_reg, 16'h00A9);
        check("R3", "narrow result", result_reg, 16'h00A9);

        // Reset in the middle of a run.
        mode = 2'd2; count_sel = 3'd2; scale_sel = 2'd0;
        send(10'h3FF);
        send(10'h3FF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "sample cleared mid-run", sample_reg, 16'h0000);
        check("R1", "result cleared mid-run", result_reg, 16'h0000);
        for (int j = 0; j < 4; j++) send(10'h001);
        check("R1", "run restarted after reset", result_reg, 16'h0004);
        idle_hold(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule